// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

This block keeps a free-running 32-bit counter and a 32-bit compare value for a processor's system-control space. The counter steps by one on every cycle in which the tick-enable input is high, unless the freeze input is asserted. Software can load either register through a one-cycle write strobe with a data word.

When a counting step makes the counter equal to the compare value, the block raises a timer interrupt. The interrupt appears on one of eight output lines, chosen by a 3-bit route select, and in a pending status bit. The pending bit only changes while the extended-feature enable is high. Writing the compare register acknowledges the interrupt. The counter wraps from all ones to zero, so a compare value below the current count still matches after the wrap.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the count is 1, the compare value is 0, `tmr_pending` is 0 and all eight `irq_lines` are 0.
- R2: On each clock edge where `tick_en` is 1 and `freeze` is 0, the count increases by one. It holds on any edge where `tick_en` is 0 or `freeze` is 1.
- R3: When `cnt_we` is 1, the count takes `cnt_wdata` at that edge, ahead of any step. A load never raises the interrupt, even if the loaded value equals the compare value.
- R4: When `cmp_we` is 1, the compare value takes `cmp_wdata` at that edge.
- R5: A match is an edge on which the count steps to a value equal to the compare value. At that edge the interrupt state is set, and the routed line reads 1 at the same time as the count first reads equal.
- R6: While `freeze` is 1, the count does not step, no match occurs and no line is raised.
- R7: A compare write clears the interrupt state and drops the line at that edge. If a match falls on the same edge, the write wins.
- R8: While the interrupt is set, exactly the line `irq_lines[route_sel]` is 1. A change of `route_sel` moves the interrupt to the new line at once, with no clock edge, and the old line drops at the same moment.
- R9: `tmr_pending` is set by a match and cleared by a compare write, but only while `ext_en` is 1. While `ext_en` is 0 it holds its value. `irq_lines` follows R5 and R7 whatever the value of `ext_en`.
- R10: The count wraps from 0xFFFFFFFF to 0. A compare value of 0 matches on that wrapping step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting step enable, one pulse per tick period |
| freeze | input | 1 | Stops counting and suppresses matches |
| ext_en | input | 1 | Allows updates of the pending status bit |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| cmp_we | input | 1 | Compare write strobe; also acknowledges the interrupt |
| cmp_wdata | input | 32 | Compare write value |
| route_sel | input | 3 | Index of the interrupt line to drive |
| count_q | output | 32 | Current count |
| compare_q | output | 32 | Current compare value |
| tmr_pending | output | 1 | Timer-interrupt pending status |
| irq_lines | output | 8 | Interrupt outputs, at most one high |

## Verification
Count, compare, pending and the interrupt state are all registered. Their effects show on the ports just after the clock edge that samples the stimulus: one edge after a write, and one edge per step. The routed line is combinational from `route_sel` and the interrupt state, so a change of route is visible within the same cycle. The bench drives inputs shortly after each rising edge and reads outputs before the next edge. It checks the count against its own running model after every cycle. It then sweeps match distances, all eight routes, freeze, the same-edge write conflict and the wrap.

// File: rtl/tm_pkg.sv
package tm_pkg;
  parameter int unsigned TM_CNT_W = 32;
  typedef logic [TM_CNT_W-1:0] tm_word_t;

  // next value of the counter for one step (wraps naturally)
  function automatic tm_word_t tm_step(input tm_word_t cur);
    return cur + tm_word_t'(1);
  endfunction

  // true when stepping from cur lands exactly on cmp
  function automatic logic tm_lands_on(input tm_word_t cur, input tm_word_t cmp);
    return (tm_step(cur) == cmp);
  endfunction
endpackage

// File: rtl/tm_counter.sv
module tm_counter
  import tm_pkg::*;
#(
  parameter tm_word_t RESET_VAL = tm_word_t'(1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     load,
  input  tm_word_t load_val,
  output tm_word_t count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= RESET_VAL;
    else if (load)   count_q <= load_val;
    else if (step)   count_q <= tm_step(count_q);
  end

  // R3: load takes effect at the next edge
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val));
  // R2: no step and no load means hold
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count_q));
  // R10: wrap from all ones to zero
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (&count_q)) |=> count_q == '0);
endmodule

// File: rtl/tm_irq_state.sv
module tm_irq_state
  import tm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     load,
  input  tm_word_t count_q,
  input  logic     cmp_we,
  input  tm_word_t cmp_wdata,
  input  logic     ext_en,
  output tm_word_t compare_q,
  output logic     hit,
  output logic     irq_flag,
  output logic     pending_q
);
  // match event: a real step (not a load) landing on compare
  assign hit = step && !load && tm_lands_on(count_q, compare_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      compare_q <= '0;
    else if (cmp_we) compare_q <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_flag <= 1'b0;
    else if (cmp_we) irq_flag <= 1'b0;
    else if (hit)    irq_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pending_q <= 1'b0;
    else if (ext_en && cmp_we) pending_q <= 1'b0;
    else if (ext_en && hit)    pending_q <= 1'b1;
  end

  // R7: compare write acknowledges
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !irq_flag);
  // R5: a match sets the interrupt state
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmp_we) |=> irq_flag && (count_q == compare_q));
  // R9: pending frozen while the extended enable is low
  p_pend_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |=> $stable(pending_q));
  // R4: compare write lands at the next edge
  p_cmp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> compare_q == $past(cmp_wdata));
endmodule

// File: rtl/tm_router.sv
module tm_router #(
  parameter int unsigned LINES = 8,
  localparam int unsigned SEL_W = $clog2(LINES)
) (
  input  logic             irq_flag,
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] lines
);
  always_comb begin
    lines = '0;
    for (int i = 0; i < LINES; i++) begin
      if (irq_flag && (sel == SEL_W'(i))) lines[i] = 1'b1;
    end
  end

  // R8: at most one line, and the chosen one when set
  always_comb begin
    a_onehot_r8: assert ($onehot0(lines));
    a_route_r8: assert (!irq_flag || lines[sel]);
  end
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tm_pkg::*;
#(
  parameter int unsigned LINES = 8,
  localparam int unsigned SEL_W = $clog2(LINES),
  localparam int unsigned W = TM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic             ext_en,
  input  logic             cnt_we,
  input  logic [W-1:0]     cnt_wdata,
  input  logic             cmp_we,
  input  logic [W-1:0]     cmp_wdata,
  input  logic [SEL_W-1:0] route_sel,
  output logic [W-1:0]     count_q,
  output logic [W-1:0]     compare_q,
  output logic             tmr_pending,
  output logic [LINES-1:0] irq_lines
);
  logic step_ev;
  logic hit_ev;
  logic irq_flag;

  assign step_ev = tick_en && !freeze;

  tm_counter #(.RESET_VAL(tm_word_t'(1))) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step_ev), .load(cnt_we),
    .load_val(cnt_wdata), .count_q(count_q)
  );

  tm_irq_state u_irq (
    .clk(clk), .rst_n(rst_n), .step(step_ev), .load(cnt_we),
    .count_q(count_q), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ext_en(ext_en), .compare_q(compare_q), .hit(hit_ev),
    .irq_flag(irq_flag), .pending_q(tmr_pending)
  );

  tm_router #(.LINES(LINES)) u_route (
    .irq_flag(irq_flag), .sel(route_sel), .lines(irq_lines)
  );

  // R6: frozen counter never matches
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !hit_ev);
  // R1: reset values seen on the first edge out of reset
  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (count_q == W'(1)) && (compare_q == '0) && (irq_lines == '0));
endmodule

// File: tb/tick_match_timer_tb.sv
module tick_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 0, freeze = 0, ext_en = 0, cnt_we = 0, cmp_we = 0;
  logic [31:0] cnt_wdata = '0, cmp_wdata = '0;
  logic [2:0]  route_sel = '0;
  logic [31:0] count_q, compare_q;
  logic        tmr_pending;
  logic [7:0]  irq_lines;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_cnt;

  always #10 clk = ~clk;

  tick_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze), .ext_en(ext_en),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .route_sel(route_sel), .count_q(count_q), .compare_q(compare_q),
    .tmr_pending(tmr_pending), .irq_lines(irq_lines)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: advance the bench's own count model, then sample after the edge
  task automatic cyc();
    if (cnt_we) m_cnt = cnt_wdata;
    else if (tick_en && !freeze) m_cnt = m_cnt + 32'd1;
    @(posedge clk); #1;
    cnt_we = 0; cmp_we = 0;
    chk("R2 count model", count_q, m_cnt);
  endtask

  function automatic logic [7:0] line_of(input logic [2:0] s);
    return 8'(1) << s;
  endfunction

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_cnt = 32'd1;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    chk("R1 count", count_q, 32'd1);
    chk("R1 compare", compare_q, 32'd0);
    chk("R1 pending", {31'd0, tmr_pending}, 32'd0);
    chk("R1 lines", {24'd0, irq_lines}, 32'd0);
    ext_en = 1;

    // R2: steady and sparse ticking, then frozen
    tick_en = 1; repeat (5) cyc();
    chk("R2 after five", count_q, 32'd6);
    for (int i = 0; i < 12; i++) begin tick_en = (i % 3 == 0); cyc(); end
    tick_en = 1; freeze = 1; repeat (4) cyc();
    chk("R2 frozen hold", count_q, 32'd10);
    freeze = 0;

    // R3: load wins over tick; load equal to compare raises nothing
    cnt_we = 1; cnt_wdata = 32'h100; cyc();
    chk("R3 load", count_q, 32'h100);
    cyc();
    chk("R3 continue", count_q, 32'h101);
    tick_en = 0; cnt_we = 1; cnt_wdata = compare_q; cyc();
    chk("R3 load no irq", {24'd0, irq_lines}, 32'd0);

    // R4/R5/R7/R8: sweep match distances and routes
    for (int d = 1; d <= 8; d++) begin
      route_sel = 3'(d - 1);
      tick_en = 0; cmp_we = 1; cmp_wdata = m_cnt + 32'(d); cyc();
      chk("R4 compare", compare_q, m_cnt + 32'(d));
      chk("R7 lines dropped", {24'd0, irq_lines}, 32'd0);
      chk("R7 pending cleared", {31'd0, tmr_pending}, 32'd0);
      tick_en = 1;
      for (int k = 1; k < d; k++) begin
        cyc();
        chk("R5 early", {24'd0, irq_lines}, 32'd0);
      end
      cyc();
      chk("R5 line", {24'd0, irq_lines}, {24'd0, line_of(route_sel)});
      chk("R9 pending set", {31'd0, tmr_pending}, 32'd1);
    end
    tick_en = 0;

    // R8: move across all lines while set, no edge needed
    for (int s = 0; s < 8; s++) begin
      route_sel = 3'(s); #1;
      chk("R8 route", {24'd0, irq_lines}, {24'd0, line_of(3'(s))});
    end

    // R7: compare write on the same edge as a match
    cmp_we = 1; cmp_wdata = m_cnt + 32'd1; cyc();
    tick_en = 1; cmp_we = 1; cmp_wdata = 32'h5555; cyc();
    chk("R7 conflict lines", {24'd0, irq_lines}, 32'd0);
    chk("R7 conflict pending", {31'd0, tmr_pending}, 32'd0);

    // R6: frozen at compare-1 never matches
    tick_en = 0; cmp_we = 1; cmp_wdata = m_cnt + 32'd1; cyc();
    tick_en = 1; freeze = 1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R6 no line", {24'd0, irq_lines}, 32'd0);
    end
    freeze = 0; route_sel = 3'd2; cyc();
    chk("R6 resumes", {24'd0, irq_lines}, 32'd4);

    // R9: with ext_en low, pending holds but lines still follow
    tick_en = 0; ext_en = 0; cmp_we = 1; cmp_wdata = m_cnt + 32'd2; cyc();
    chk("R9 pending held", {31'd0, tmr_pending}, 32'd1);
    chk("R9 lines dropped", {24'd0, irq_lines}, 32'd0);
    ext_en = 1; cmp_we = 1; cyc();
    chk("R9 cleared", {31'd0, tmr_pending}, 32'd0);
    ext_en = 0; tick_en = 1; cyc(); cyc();
    chk("R9 line w/o ext", {24'd0, irq_lines}, 32'd4);
    chk("R9 pending stays", {31'd0, tmr_pending}, 32'd0);
    ext_en = 1;

    // R10: wrap and match on zero
    tick_en = 0; cnt_we = 1; cnt_wdata = 32'hFFFF_FFFE; cmp_we = 1; cmp_wdata = 32'd0; cyc();
    tick_en = 1; cyc();
    chk("R10 before wrap", {24'd0, irq_lines}, 32'd0);
    cyc();
    chk("R10 wrapped", count_q, 32'd0);
    chk("R10 match", {24'd0, irq_lines}, 32'd4);
    tick_en = 0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule